// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity Error Signalling

This block is a character transceiver for a smart-card style serial link. Transmit and receive share one wire. The block pulls the wire low through an open-drain output (`line_drive_low`) and reads the resulting wire level back on `line_in`. Each character is framed as one low start bit, eight data bits with the least significant bit first, one even-parity bit and one high stop bit. No bit is inverted. The bit time is 16 × (divisor + 1) clock cycles.

When the receiver sees a character whose parity is wrong, it holds the wire low for exactly one bit time, starting at the stop-bit boundary. This tells the far end that the character was bad. The transmitter reads the wire in the middle of its own stop bit. If it finds the wire low there, it records that the far end rejected the character.

Software-facing logic connects through four groups of signals:
- a one-entry transmit buffer with a write strobe;
- a receive buffer with a read strobe;
- sticky error flags, cleared by `stat_clr`;
- two interrupt request levels, each cleared by its own acknowledge input.

The transmitter has five states: `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_PARITY` and `TX_STOP`. Its transitions are:
- `TX_IDLE` goes to `TX_START` when the buffer holds a character.
- Each later state advances at the end of its bit. `TX_DATA` advances after the eighth bit.
- `TX_STOP` returns to `TX_IDLE`.

The receiver has six states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PARITY`, `RX_STOP` and `RX_ERRSIG`. Its transitions are:
- `RX_IDLE` goes to `RX_START` on a falling wire edge, but only while the transmitter is idle.
- `RX_START` returns to `RX_IDLE` if the wire is high at mid-bit. Otherwise it goes to `RX_DATA` at the end of the bit.
- `RX_DATA` goes to `RX_PARITY` after eight bits.
- `RX_PARITY` goes to `RX_STOP` when parity is good, or to `RX_ERRSIG` when it is bad.
- `RX_STOP` returns to `RX_IDLE` at mid-bit.
- `RX_ERRSIG` returns to `RX_IDLE` at the end of its bit.

Top module: `sc_uart`

## Requirements
- R1: A transmitted character appears on the wire as: a low start bit, then data bits 0 through 7, then a parity bit equal to the XOR of the data bits (even parity), then a high stop bit. A low bit is a pulled-down wire. The wire is released while the transmitter is idle.
- R2: Every bit lasts exactly 16 × (divisor + 1) clock cycles.
- R3: A write with `tx_wr` goes into the buffer, and `tx_buf_empty` falls. The character moves into the shift register on the second clock edge after the write if the transmitter is idle. `tx_buf_empty` rises at that move. A character written during a transmission is sent straight after the current one.
- R4: `tx_irq` is not set when the buffer empties. It is set on the edge where the stop bit ends and `tx_shift_empty` rises. It stays set until `tx_irq_ack`.
- R5: The receiver starts on a falling edge of the wire and samples each bit at mid-bit. A low pulse that has ended before mid start bit is dropped, and no character results from it.
- R6: A received character is placed in `rx_rdata` at mid stop bit. At the same moment `rx_full` and `rx_irq` are set. `rx_rd` clears `rx_full`, and `rx_irq_ack` clears `rx_irq`.
- R7: On a parity mismatch, the block holds `line_drive_low` high for exactly one bit time, starting at the stop-bit boundary. It delivers the character when that bit time ends, with the sticky `rx_par_err` set.
- R8: If the wire is low at mid stop bit of a transmitted character, the sticky `tx_nak_seen` flag is set. A character whose stop bit stays high leaves the flag clear. `stat_clr` clears the flag.
- R9: The block's own transmitted bits, echoed back on `line_in`, are never taken as a received character.
- R10: If a character completes while `rx_full` is set, the sticky `rx_overrun` flag is set. The new character is discarded and `rx_rdata` keeps the unread one.
- R11: After reset the wire is released. Both buffers and the shift register read as empty, and all interrupts and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and bit-timer count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Bit-time divisor n; bit = 16 × (n + 1) clocks |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | DATA_W | Character to transmit |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_rdata | output | DATA_W | Last received character |
| tx_irq_ack | input | 1 | Clears `tx_irq` |
| rx_irq_ack | input | 1 | Clears `rx_irq` |
| stat_clr | input | 1 | Clears the sticky error flags |
| line_in | input | 1 | Level of the shared wire |
| line_drive_low | output | 1 | Open-drain pull-down request for the wire |
| tx_buf_empty | output | 1 | Transmit buffer can take a character |
| tx_shift_empty | output | 1 | Transmitter idle |
| tx_irq | output | 1 | Transmission-complete interrupt request |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_irq | output | 1 | Receive-complete interrupt request |
| rx_par_err | output | 1 | Sticky: a character arrived with bad parity |
| rx_overrun | output | 1 | Sticky: a character was lost to overrun |
| tx_nak_seen | output | 1 | Sticky: the far end signalled a parity error |

## Verification
Transmit results are due at fixed cycle offsets:
- A write reaches the shift register two edges after the strobe. The start bit is driven from that edge.
- The bench's frame decoder therefore waits half a bit time (8 × (n + 1) cycles) from the first low cycle, then samples once per bit time.
- `tx_irq` and `tx_shift_empty` are compared on the cycle after the stop bit ends.

Receive results depend on the two-flop input synchronizer plus the edge detector, which add about three cycles:
- The receive scoreboard therefore waits for `rx_irq` and does not count cycles to it.
- The error pulse width is measured as an exact count of cycles, and its level is checked at mid stop bit.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;

    localparam int unsigned OVS = 16;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_ERRSIG
    } rx_state_t;

endpackage

// File: rtl/sc_uart_bittimer.sv
module sc_uart_bittimer
    import sc_uart_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             mid_pt,
    output logic             bit_end
);
    localparam int unsigned SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

    logic [DIV_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic             tick;

    assign tick    = run && (pre_q == divisor);
    assign mid_pt  = tick && (sub_q == SUB_MID);
    assign bit_end = tick && (sub_q == SUB_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_MID_NOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        mid_pt |-> !bit_end) else $error("mid and end coincide"); // R2

endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
    import sc_uart_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              line_s,
    input  logic              irq_ack,
    input  logic              stat_clr,
    output logic              drive_low,
    output logic              buf_empty,
    output logic              busy,
    output logic              irq,
    output logic              nak_seen
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] buf_q;
    logic              buf_full_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    logic [IDX_W-1:0]  idx_q;
    logic              irq_q;
    logic              nak_q;
    logic              mid_pt;
    logic              bit_end;
    logic              load;

    sc_uart_bittimer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != TX_IDLE),
        .divisor (divisor),
        .mid_pt  (mid_pt),
        .bit_end (bit_end)
    );

    assign load = (state_q == TX_IDLE) && buf_full_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (buf_full_q) state_d = TX_START;
            TX_START:  if (bit_end) state_d = TX_DATA;
            TX_DATA:   if (bit_end && idx_q == IDX_LAST) state_d = TX_PARITY;
            TX_PARITY: if (bit_end) state_d = TX_STOP;
            TX_STOP:   if (bit_end) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // line output
    always_comb begin
        drive_low = 1'b0;
        unique case (state_q)
            TX_START:  drive_low = 1'b1;
            TX_DATA:   drive_low = ~sh_q[0];
            TX_PARITY: drive_low = ~par_q;
            default:   drive_low = 1'b0;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
            sh_q       <= '0;
            par_q      <= 1'b0;
            idx_q      <= '0;
            irq_q      <= 1'b0;
            nak_q      <= 1'b0;
        end else begin
            if (load) begin
                buf_full_q <= 1'b0;
                sh_q       <= buf_q;
                par_q      <= ^buf_q;
                idx_q      <= '0;
            end
            if (wr) begin
                buf_full_q <= 1'b1;
                buf_q      <= wdata;
            end
            if (state_q == TX_DATA && bit_end) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
            if (irq_ack) irq_q <= 1'b0;
            if (state_q == TX_STOP && bit_end) irq_q <= 1'b1;
            if (stat_clr) nak_q <= 1'b0;
            if (state_q == TX_STOP && mid_pt && !line_s) nak_q <= 1'b1;
        end
    end

    assign buf_empty = !buf_full_q;
    assign busy      = (state_q != TX_IDLE);
    assign irq       = irq_q;
    assign nak_seen  = nak_q;

    AST_LOAD_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && buf_full_q) |=> (state_q == TX_START)) else $error("load"); // R3
    AST_IRQ_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(state_q) == TX_STOP && state_q == TX_IDLE)) else $error("irq"); // R4
    AST_NAK_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nak_q) |-> ($past(state_q) == TX_STOP)) else $error("nak"); // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> !drive_low) else $error("idle drive"); // R1

endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
    import sc_uart_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              line_s,
    input  logic              tx_busy,
    input  logic              rd,
    input  logic              irq_ack,
    input  logic              stat_clr,
    output logic              err_low,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              irq,
    output logic              par_err,
    output logic              overrun
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_state_t         state_q, state_d;
    logic              line_q;
    logic              fall;
    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] buf_q;
    logic              full_q;
    logic              irq_q;
    logic              perr_q;
    logic              ovr_q;
    logic              mid_pt;
    logic              bit_end;
    logic              bad_par;
    logic              done;

    sc_uart_bittimer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != RX_IDLE),
        .divisor (divisor),
        .mid_pt  (mid_pt),
        .bit_end (bit_end)
    );

    assign fall    = line_q && !line_s;
    assign bad_par = ^{sh_q, par_q};
    assign done    = (state_q == RX_STOP && mid_pt) || (state_q == RX_ERRSIG && bit_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (fall && !tx_busy) state_d = RX_START;
            RX_START: begin
                if (mid_pt && line_s) state_d = RX_IDLE;
                else if (bit_end)     state_d = RX_DATA;
            end
            RX_DATA:   if (bit_end && idx_q == IDX_LAST) state_d = RX_PARITY;
            RX_PARITY: if (bit_end) state_d = bad_par ? RX_ERRSIG : RX_STOP;
            RX_STOP:   if (mid_pt) state_d = RX_IDLE;
            RX_ERRSIG: if (bit_end) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // line output: error pulse
    always_comb begin
        err_low = 1'b0;
        unique case (state_q)
            RX_ERRSIG: err_low = 1'b1;
            default:   err_low = 1'b0;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b1;
            sh_q   <= '0;
            par_q  <= 1'b0;
            idx_q  <= '0;
            buf_q  <= '0;
            full_q <= 1'b0;
            irq_q  <= 1'b0;
            perr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            line_q <= line_s;
            if (state_q == RX_IDLE) idx_q <= '0;
            if (state_q == RX_DATA && mid_pt) sh_q <= {line_s, sh_q[DATA_W-1:1]};
            if (state_q == RX_DATA && bit_end) idx_q <= idx_q + 1'b1;
            if (state_q == RX_PARITY && mid_pt) par_q <= line_s;
            if (rd) full_q <= 1'b0;
            if (irq_ack) irq_q <= 1'b0;
            if (stat_clr) begin
                perr_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (done) begin
                if (full_q && !rd) begin
                    ovr_q <= 1'b1;
                end else begin
                    buf_q  <= sh_q;
                    full_q <= 1'b1;
                    irq_q  <= 1'b1;
                    if (state_q == RX_ERRSIG) perr_q <= 1'b1;
                end
            end
        end
    end

    assign rdata   = buf_q;
    assign full    = full_q;
    assign irq     = irq_q;
    assign par_err = perr_q;
    assign overrun = ovr_q;

    AST_FALSE_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && mid_pt && line_s) |=> (state_q == RX_IDLE)) else $error("start"); // R5
    AST_ERR_AFTER_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_low) |-> ($past(state_q) == RX_PARITY)) else $error("errsig"); // R7
    AST_ECHO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && tx_busy) |=> (state_q == RX_IDLE)) else $error("echo"); // R9
    AST_UNREAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !rd) |=> $stable(buf_q)) else $error("overrun"); // R10

endmodule

// File: rtl/sc_uart.sv
module sc_uart
    import sc_uart_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              tx_irq_ack,
    input  logic              rx_irq_ack,
    input  logic              stat_clr,
    input  logic              line_in,
    output logic              line_drive_low,
    output logic              tx_buf_empty,
    output logic              tx_shift_empty,
    output logic              tx_irq,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              rx_par_err,
    output logic              rx_overrun,
    output logic              tx_nak_seen
);
    logic [1:0] sync_q;
    logic       line_s;
    logic       tx_low;
    logic       tx_busy;
    logic       rx_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_in};
    end
    assign line_s = sync_q[1];

    sc_uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor   (divisor),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .line_s    (line_s),
        .irq_ack   (tx_irq_ack),
        .stat_clr  (stat_clr),
        .drive_low (tx_low),
        .buf_empty (tx_buf_empty),
        .busy      (tx_busy),
        .irq       (tx_irq),
        .nak_seen  (tx_nak_seen)
    );

    sc_uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .divisor  (divisor),
        .line_s   (line_s),
        .tx_busy  (tx_busy),
        .rd       (rx_rd),
        .irq_ack  (rx_irq_ack),
        .stat_clr (stat_clr),
        .err_low  (rx_low),
        .rdata    (rx_rdata),
        .full     (rx_full),
        .irq      (rx_irq),
        .par_err  (rx_par_err),
        .overrun  (rx_overrun)
    );

    assign line_drive_low = tx_low | rx_low;
    assign tx_shift_empty = !tx_busy;

    AST_HALF_DUPLEX_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_low |-> !tx_low) else $error("both drive"); // R9

endmodule

// File: tb/sc_uart_tb_top.sv
module sc_uart_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] divisor = 8'd1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_rdata;
    logic       tx_irq_ack = 1'b0;
    logic       rx_irq_ack = 1'b0;
    logic       stat_clr = 1'b0;
    logic       line_drive_low;
    logic       tx_buf_empty, tx_shift_empty, tx_irq;
    logic       rx_full, rx_irq, rx_par_err, rx_overrun, tx_nak_seen;
    logic       card_low_s = 1'b0;
    logic       card_low_n = 1'b0;
    wire        line = ~(line_drive_low | card_low_s | card_low_n);

    int checks = 0;
    int failures = 0;
    int bit_cycles = 32;
    bit rx_mon_en = 1'b1;
    int rx_seen = 0;
    int err_run = 0;
    int err_len = 0;
    logic [8:0] tx_q[$];
    logic [8:0] rx_q[$];

    always #2 clk = ~clk;

    sc_uart dut_i (
        .clk(clk), .rst_n(rst_n), .divisor(divisor),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .tx_irq_ack(tx_irq_ack), .rx_irq_ack(rx_irq_ack), .stat_clr(stat_clr),
        .line_in(line), .line_drive_low(line_drive_low),
        .tx_buf_empty(tx_buf_empty), .tx_shift_empty(tx_shift_empty), .tx_irq(tx_irq),
        .rx_full(rx_full), .rx_irq(rx_irq), .rx_par_err(rx_par_err),
        .rx_overrun(rx_overrun), .tx_nak_seen(tx_nak_seen)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: transmit side
    task automatic tx_write(input logic [7:0] d, input bit nak);
        tx_q.push_back({nak, d});
        tx_wdata = d;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_tx_idle();
        @(negedge clk);
        while (!(tx_q.size() == 0 && tx_shift_empty && tx_buf_empty)) @(negedge clk);
    endtask

    // driver: card side sending to the block
    task automatic card_send(input logic [7:0] d, input bit badp, input bit expect_it);
        logic p;
        p = (^d) ^ badp;
        if (expect_it) rx_q.push_back({badp, d});
        card_low_s = 1'b1;
        wait_clk(bit_cycles);
        for (int i = 0; i < 8; i++) begin
            card_low_s = ~d[i];
            wait_clk(bit_cycles);
        end
        card_low_s = ~p;
        wait_clk(bit_cycles);
        card_low_s = 1'b0;
        wait_clk(bit_cycles / 2);
        check(line_drive_low == badp, "R7", "error pulse at mid stop", line_drive_low, badp);
        wait_clk(bit_cycles / 2);
        wait_clk(2 * bit_cycles);
    endtask

    // monitor: decode frames the block transmits
    initial begin : tx_monitor
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (line_drive_low && !prev && !tx_shift_empty) begin
                logic [7:0] got;
                logic       pbit, sbit, nak;
                logic [8:0] exp;
                exp = (tx_q.size() != 0) ? tx_q[0] : 9'h000;
                nak = exp[8];
                got = '0;
                wait_clk(bit_cycles / 2);
                check(line == 1'b0, "R1", "start bit low", line, 0);
                for (int i = 0; i < 8; i++) begin
                    wait_clk(bit_cycles);
                    got[i] = line;
                end
                wait_clk(bit_cycles);
                pbit = line;
                if (nak) begin
                    wait_clk(bit_cycles / 2);
                    card_low_n = 1'b1;
                    wait_clk(bit_cycles);
                    card_low_n = 1'b0;
                    sbit = 1'b1;
                end else begin
                    wait_clk(bit_cycles);
                    sbit = line;
                end
                if (tx_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected tx frame", got, 0);
                end else begin
                    void'(tx_q.pop_front());
                    check(got == exp[7:0], "R1", "tx data", got, exp[7:0]);
                    check(pbit == ^exp[7:0], "R1", "tx even parity", pbit, ^exp[7:0]);
                    check(sbit == 1'b1, "R1", "tx stop high", sbit, 1);
                end
            end
            prev = line_drive_low;
        end
    end

    // monitor: receive scoreboard
    initial begin : rx_monitor
        forever begin
            @(negedge clk);
            if (rx_mon_en && rx_irq) begin
                rx_seen++;
                if (rx_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected rx char", rx_rdata, 0);
                end else begin
                    logic [8:0] e;
                    e = rx_q.pop_front();
                    check(rx_rdata == e[7:0], "R6", "rx data", rx_rdata, e[7:0]);
                    check(rx_full == 1'b1, "R6", "rx_full set", rx_full, 1);
                    check(rx_par_err == e[8], "R7", "rx parity flag", rx_par_err, e[8]);
                end
                rx_rd = 1'b1;
                rx_irq_ack = 1'b1;
                @(negedge clk);
                rx_rd = 1'b0;
                rx_irq_ack = 1'b0;
            end
        end
    end

    // error pulse width while the transmitter is idle
    always @(negedge clk) begin
        if (line_drive_low && tx_shift_empty) err_run++;
        else if (err_run != 0) begin
            err_len = err_run;
            err_run = 0;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        report();
    end

    task automatic pulse_clr();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    initial begin : main
        int cnt;
        int seen0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R11 reset state
        check(line_drive_low == 0, "R11", "line released", line_drive_low, 0);
        check(tx_buf_empty == 1 && tx_shift_empty == 1, "R11", "tx empty",
              {tx_buf_empty, tx_shift_empty}, 3);
        check(rx_full == 0 && rx_irq == 0 && tx_irq == 0, "R11", "irq/full low",
              {rx_full, rx_irq, tx_irq}, 0);
        check({rx_par_err, rx_overrun, tx_nak_seen} == 0, "R11", "flags low",
              {rx_par_err, rx_overrun, tx_nak_seen}, 0);

        // R1 R3 R4 single character
        tx_write(8'hA5, 1'b0);
        @(negedge clk);
        check(tx_buf_empty == 1 && tx_shift_empty == 0, "R3", "moved to shift reg",
              {tx_buf_empty, tx_shift_empty}, 2);
        check(tx_irq == 0, "R4", "no irq on buffer transfer", tx_irq, 0);
        wait_tx_idle();
        check(tx_irq == 1, "R4", "irq at frame end", tx_irq, 1);
        tx_irq_ack = 1'b1;
        @(negedge clk);
        tx_irq_ack = 1'b0;
        check(tx_irq == 0, "R4", "irq cleared by ack", tx_irq, 0);
        check(rx_full == 0 && rx_seen == 0, "R9", "own echo not received", rx_full, 0);

        // R3 back-to-back
        tx_write(8'h3C, 1'b0);
        wait_clk(5);
        tx_write(8'h81, 1'b0);
        check(tx_buf_empty == 0, "R3", "buffer held while busy", tx_buf_empty, 0);
        wait_tx_idle();
        check(rx_seen == 0, "R9", "no echo after two frames", rx_seen, 0);
        tx_irq_ack = 1'b1;
        @(negedge clk);
        tx_irq_ack = 1'b0;

        // R8 far end signals an error
        tx_write(8'h7E, 1'b1);
        wait_tx_idle();
        wait_clk(bit_cycles);
        check(tx_nak_seen == 1, "R8", "nak detected", tx_nak_seen, 1);
        pulse_clr();
        check(tx_nak_seen == 0, "R8", "nak cleared", tx_nak_seen, 0);
        tx_write(8'h01, 1'b0);
        wait_tx_idle();
        check(tx_nak_seen == 0, "R8", "no nak on clean stop", tx_nak_seen, 0);
        wait_clk(bit_cycles);

        // R6 good characters from the card
        card_send(8'h5A, 1'b0, 1'b1);
        card_send(8'hC3, 1'b0, 1'b1);
        check(rx_full == 0 && rx_q.size() == 0, "R6", "read clears full", rx_full, 0);

        // R7 bad parity
        card_send(8'h96, 1'b1, 1'b1);
        check(err_len == bit_cycles, "R7", "error pulse width", err_len, bit_cycles);
        pulse_clr();
        check(rx_par_err == 0, "R7", "parity flag cleared", rx_par_err, 0);

        // R5 glitch rejected
        seen0 = rx_seen;
        card_low_s = 1'b1;
        wait_clk(4);
        card_low_s = 1'b0;
        wait_clk(20 * bit_cycles);
        check(rx_seen == seen0 && rx_full == 0, "R5", "glitch ignored", rx_seen - seen0, 0);
        card_send(8'h24, 1'b0, 1'b1);
        check(rx_seen == seen0 + 1, "R5", "receive after glitch", rx_seen - seen0, 1);

        // R10 overrun
        rx_mon_en = 1'b0;
        card_send(8'h11, 1'b0, 1'b0);
        card_send(8'h22, 1'b0, 1'b0);
        check(rx_overrun == 1, "R10", "overrun flag", rx_overrun, 1);
        check(rx_rdata == 8'h11, "R10", "old data kept", rx_rdata, 8'h11);
        rx_rd = 1'b1;
        rx_irq_ack = 1'b1;
        stat_clr = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        rx_irq_ack = 1'b0;
        stat_clr = 1'b0;
        check(rx_full == 0 && rx_overrun == 0, "R10", "cleared after read",
              {rx_full, rx_overrun}, 0);
        rx_mon_en = 1'b1;

        // R2 bit time with another divisor
        divisor = 8'd3;
        bit_cycles = 64;
        tx_write(8'hFF, 1'b0);
        @(negedge clk);
        cnt = 0;
        while (line_drive_low) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 64, "R2", "start bit length", cnt, 64);
        wait_tx_idle();
        card_send(8'h6B, 1'b0, 1'b1);
        check(rx_q.size() == 0, "R2", "rx at divisor 3", rx_q.size(), 0);

        wait_clk(10);
        report();
    end

endmodule